// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Unit

This unit sits beside a CPU core and watches two address streams: the instruction-fetch address and the data-memory access address. It has four comparator slots. When an enabled slot matches an access, it asks the core to halt. The request is one registered pulse, and a sticky flag records which slot fired. A debug controller programs the slots through a plain register-write port. A two-bit mode register sets how the two upper slots are used:

- Split mode: both upper slots are independent data breakpoints.
- Program-range mode: the two upper slots act together as one masked program-address breakpoint.
- Data-range mode: the two upper slots act together as one masked data-address breakpoint.

The two lower slots are always exact program-address breakpoints, in every mode.

A security input, `dbgEnable`, gates the whole unit. While it is low, no access can raise a request or set a flag, and configuration writes have no effect. The unit is used by writing slot values, slot controls and the mode. The core then takes `breakReq` as its halt request, and the debug controller watches `hitFlags` and clears them by writing ones.

Top module: `brk_match_top`

## Requirements
- R1: After reset, `breakReq` is 0, `hitFlags` is 0, the mode is split and every slot is disabled, so no access matches until the slots are configured.
- R2: Register map on `cfgAddr`:
  - Addresses 0 to 3 hold the compare value of slots 0 to 3.
  - Addresses 4 to 7 hold the control of slots 0 to 3. Bit 0 is enable, bit 1 is read-qualify, bit 2 is write-qualify.
  - Address 8 holds the mode in bits [1:0]: 0 is split, 1 is program-range, 2 is data-range, and 3 behaves as split.
  - Address 9 is the flag-clear register.
- R3: In every mode, slots 0 and 1 match when `fetchValid` is high and `fetchAddr` equals the slot value.
- R4: A slot whose enable bit is 0 never matches, whatever the addresses and the mode.
- R5: In split mode, slots 2 and 3 compare `dataAddr` exactly. A slot fires on a read (`dataWrite`=0) only if its read-qualify bit is set, and on a write (`dataWrite`=1) only if its write-qualify bit is set.
- R6: In program-range mode, slot 2's value and slot 3's value act as a value/mask pair. The pair fires when `fetchValid` is high and `(fetchAddr & mask) == (value & mask)`, where a mask bit of 1 means the bit is compared. The pair uses slot 2's enable and reports on `hitFlags` bit 2.
- R7: In data-range mode, the same masked compare applies to `dataAddr`, qualified by slot 2's read/write bits. Slot 3's own control bits are ignored, and `hitFlags` bit 3 never sets.
- R8: `breakReq` is high in the cycle after a clock edge at which an access matched, and it lasts one cycle for a single access.
- R9: `hitFlags` bit i sets when slot i (or the pair, on bit 2) fires, and it stays set. Writing a 1 to a bit at address 9 clears that bit. A new hit in the same cycle as a clear leaves the bit set.
- R10: While `dbgEnable` is low, `breakReq` stays low, no flag sets, and configuration writes are ignored.
- R11: A program hit and a data hit in the same cycle set both flags and give one `breakReq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbgEnable | input | 1 | Security gate; the unit is inert when low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW (4) | Configuration register address |
| cfgData | input | VAL_W (16) | Configuration write data |
| fetchValid | input | 1 | Instruction fetch this cycle |
| fetchAddr | input | PC_W (16) | Instruction fetch address |
| dataValid | input | 1 | Data access this cycle |
| dataWrite | input | 1 | 1 for write, 0 for read |
| dataAddr | input | DA_W (16) | Data access address |
| breakReq | output | 1 | Registered halt request pulse |
| hitFlags | output | 4 | Sticky per-slot hit flags |

## Verification
The bench targets the access qualifiers in split mode. A design that ignored them would halt on a read when only writes were selected, or the reverse.

In the two range modes it uses addresses that differ only inside and only outside the mask. This exposes an inverted mask sense, or a pair routed to the wrong bus.

It tests configuration writes made while the gate is low, which a leaky gate would let through and later turn into a hit. It also issues a clear in the same cycle as a new hit, where a clear-wins design would lose the event. Finally it watches the cycle after each hit, where a level output instead of a pulse would still read high.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_SLOTS  = 4;
  localparam int PROG_SLOTS = 2;
  localparam int PAIR_LO    = 2;
  localparam int PAIR_HI    = 3;

  localparam int CTL_W  = 3;
  localparam int CTL_EN = 0;
  localparam int CTL_RD = 1;
  localparam int CTL_WR = 2;

  localparam logic [3:0] REG_VAL_BASE = 4'd0;
  localparam logic [3:0] REG_CTL_BASE = 4'd4;
  localparam logic [3:0] REG_MODE     = 4'd8;
  localparam logic [3:0] REG_CLEAR    = 4'd9;

  typedef enum logic [1:0] {
    MODE_SPLIT      = 2'd0,
    MODE_PROG_RANGE = 2'd1,
    MODE_DATA_RANGE = 2'd2,
    MODE_RSVD       = 2'd3
  } brk_mode_e;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] valWe;
    logic [NUM_SLOTS-1:0] ctlWe;
    logic                 clrWe;
  } brk_strobe_t;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic         eq
);
  assign eq = ((addr ^ value) & mask) == '0;
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbgEnable,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [1:0]        modeData,
  output brk_strobe_t       stb,
  output brk_mode_e         mode
);
  logic weOk;
  assign weOk = cfgWe & dbgEnable;

  always_comb begin
    stb = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      stb.valWe[i] = weOk && (cfgAddr == CFG_AW'(REG_VAL_BASE + i));
      stb.ctlWe[i] = weOk && (cfgAddr == CFG_AW'(REG_CTL_BASE + i));
    end
    stb.clrWe = weOk && (cfgAddr == CFG_AW'(REG_CLEAR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode <= MODE_SPLIT;
    else if (weOk && cfgAddr == CFG_AW'(REG_MODE))
      mode <= brk_mode_e'(modeData);
  end
endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DA_W  = 16,
  parameter int VAL_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  brk_strobe_t          stb,
  input  logic [VAL_W-1:0]     wdata,
  input  brk_mode_e            mode,
  input  logic                 gateOn,
  input  logic                 fetchValid,
  input  logic [PC_W-1:0]      fetchAddr,
  input  logic                 dataValid,
  input  logic                 dataWrite,
  input  logic [DA_W-1:0]      dataAddr,
  output logic                 breakReq,
  output logic [NUM_SLOTS-1:0] hitFlags
);
  logic [VAL_W-1:0]     slotVal [NUM_SLOTS];
  logic [CTL_W-1:0]     slotCtl [NUM_SLOTS];
  logic [VAL_W-1:0]     fetchExt, dataExt, rangeAddr;
  logic [NUM_SLOTS-1:0] exactEq, qualOk, hitNow, clrBits;
  logic                 rangeEq;

  assign fetchExt  = VAL_W'(fetchAddr);
  assign dataExt   = VAL_W'(dataAddr);
  assign rangeAddr = (mode == MODE_PROG_RANGE) ? fetchExt : dataExt;
  assign clrBits   = stb.clrWe ? wdata[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotVal[i] <= '0;
        slotCtl[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (stb.valWe[i]) slotVal[i] <= wdata;
        if (stb.ctlWe[i]) slotCtl[i] <= wdata[CTL_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_exact
    if (g < PROG_SLOTS) begin : g_prog
      brk_cmp #(.W(VAL_W)) u_cmp (
        .addr(fetchExt), .value(slotVal[g]), .mask({VAL_W{1'b1}}), .eq(exactEq[g])
      );
    end else begin : g_data
      brk_cmp #(.W(VAL_W)) u_cmp (
        .addr(dataExt), .value(slotVal[g]), .mask({VAL_W{1'b1}}), .eq(exactEq[g])
      );
    end
    assign qualOk[g] = dataWrite ? slotCtl[g][CTL_WR] : slotCtl[g][CTL_RD];
  end

  brk_cmp #(.W(VAL_W)) u_range (
    .addr(rangeAddr), .value(slotVal[PAIR_LO]), .mask(slotVal[PAIR_HI]), .eq(rangeEq)
  );

  always_comb begin
    hitNow = '0;
    for (int i = 0; i < PROG_SLOTS; i++)
      hitNow[i] = slotCtl[i][CTL_EN] & fetchValid & exactEq[i];
    case (mode)
      MODE_PROG_RANGE:
        hitNow[PAIR_LO] = slotCtl[PAIR_LO][CTL_EN] & fetchValid & rangeEq;
      MODE_DATA_RANGE:
        hitNow[PAIR_LO] = slotCtl[PAIR_LO][CTL_EN] & dataValid & qualOk[PAIR_LO] & rangeEq;
      default:
        for (int i = PROG_SLOTS; i < NUM_SLOTS; i++)
          hitNow[i] = slotCtl[i][CTL_EN] & dataValid & qualOk[i] & exactEq[i];
    endcase
    if (!gateOn) hitNow = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      breakReq <= 1'b0;
      hitFlags <= '0;
    end else begin
      breakReq <= |hitNow;
      hitFlags <= (hitFlags & ~clrBits) | hitNow;
    end
  end
endmodule

// File: rtl/brk_match_top.sv
module brk_match_top
  import brk_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DA_W   = 16,
  parameter int CFG_AW = 4,
  localparam int VAL_W = (PC_W > DA_W) ? PC_W : DA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbgEnable,
  input  logic                 cfgWe,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [VAL_W-1:0]     cfgData,
  input  logic                 fetchValid,
  input  logic [PC_W-1:0]      fetchAddr,
  input  logic                 dataValid,
  input  logic                 dataWrite,
  input  logic [DA_W-1:0]      dataAddr,
  output logic                 breakReq,
  output logic [NUM_SLOTS-1:0] hitFlags
);
  brk_strobe_t stb;
  brk_mode_e   mode;

  brk_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dbgEnable(dbgEnable), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .modeData(cfgData[1:0]), .stb(stb), .mode(mode)
  );

  brk_datapath #(.PC_W(PC_W), .DA_W(DA_W), .VAL_W(VAL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(cfgData), .mode(mode),
    .gateOn(dbgEnable), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .dataValid(dataValid), .dataWrite(dataWrite), .dataAddr(dataAddr),
    .breakReq(breakReq), .hitFlags(hitFlags)
  );
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk #(
  parameter int CFG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbgEnable,
  input logic              cfgWe,
  input logic [CFG_AW-1:0] cfgAddr,
  input logic              fetchValid,
  input logic              dataValid,
  input logic              breakReq,
  input logic [3:0]        hitFlags
);
  // R1: outputs are clear while reset is held
  always_comb if (!rst_n) a_r1_reset_quiet: assert (!breakReq && hitFlags == 4'd0);

  // R10: a gated-off cycle never produces a request
  a_r10_gate_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !dbgEnable |=> !breakReq);

  // R8: a request only follows a cycle carrying an access
  a_r8_req_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    breakReq |-> $past(fetchValid || dataValid));

  // R9: flags persist unless a clear write is presented
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfgWe && cfgAddr == CFG_AW'(9)) |=> ((hitFlags & $past(hitFlags)) == $past(hitFlags)));

  // R9: a newly set flag coincides with a request
  a_r9_new_flag_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((hitFlags & ~$past(hitFlags)) != 4'd0) |-> breakReq);

  // R5: slot 3 can only fire on a data access
  a_r5_slot3_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitFlags[3]) |-> $past(dataValid));
endmodule

bind brk_match_top brk_match_chk #(.CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbgEnable(dbgEnable), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .fetchValid(fetchValid), .dataValid(dataValid), .breakReq(breakReq), .hitFlags(hitFlags)
);

// File: tb/brk_match_top_test.sv
module brk_match_top_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        dbgEnable = 1;
  logic        cfgWe = 0;
  logic [3:0]  cfgAddr = 0;
  logic [15:0] cfgData = 0;
  logic        fetchValid = 0;
  logic [15:0] fetchAddr = 0;
  logic        dataValid = 0;
  logic        dataWrite = 0;
  logic [15:0] dataAddr = 0;
  logic        breakReq;
  logic [3:0]  hitFlags;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  brk_match_top uut (
    .clk(clk), .rst_n(rst_n), .dbgEnable(dbgEnable), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .dataValid(dataValid), .dataWrite(dataWrite), .dataAddr(dataAddr),
    .breakReq(breakReq), .hitFlags(hitFlags)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic req, input logic [3:0] fl);
    chk(breakReq === req, {tag, " breakReq"}, 16'(breakReq), 16'(req));
    chk(hitFlags === fl, {tag, " hitFlags"}, 16'(hitFlags), 16'(fl));
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfgWe = 1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic access(input logic fv, input logic [15:0] fa,
                        input logic dv, input logic dw, input logic [15:0] da);
    fetchValid = fv; fetchAddr = fa; dataValid = dv; dataWrite = dw; dataAddr = da;
    @(negedge clk);
    fetchValid = 0; dataValid = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 4'h0);
    access(1, 16'h0000, 1, 0, 16'h0000);
    expect_out("R1 no match unconfigured", 0, 4'h0);
  endtask

  task automatic t_gate();
    dbgEnable = 0;
    wr(4'd1, 16'h0777);
    wr(4'd5, 16'h0001);
    dbgEnable = 1;
    access(1, 16'h0777, 0, 0, 0);
    expect_out("R10 write ignored while gated", 0, 4'h0);
    wr(4'd0, 16'h0010);
    wr(4'd4, 16'h0001);
    dbgEnable = 0;
    access(1, 16'h0010, 0, 0, 0);
    expect_out("R10 no hit while gated", 0, 4'h0);
    dbgEnable = 1;
  endtask

  task automatic t_prog();
    access(1, 16'h0010, 0, 0, 0);
    expect_out("R3 slot0 hit", 1, 4'h1);
    idle();
    expect_out("R8 single pulse", 0, 4'h1);
    wr(4'd1, 16'h0020);
    wr(4'd5, 16'h0001);
    access(1, 16'h0021, 0, 0, 0);
    expect_out("R3 slot1 near miss", 0, 4'h1);
    access(1, 16'h0020, 0, 0, 0);
    expect_out("R3 slot1 hit", 1, 4'h3);
    wr(4'd9, 16'h0001);
    expect_out("R9 clear bit0 only", 0, 4'h2);
    wr(4'd9, 16'h000F);
    expect_out("R9 clear all", 0, 4'h0);
  endtask

  task automatic t_disabled();
    wr(4'd4, 16'h0000);
    access(1, 16'h0010, 0, 0, 0);
    expect_out("R4 disabled slot0", 0, 4'h0);
    wr(4'd4, 16'h0001);
  endtask

  task automatic t_split();
    wr(4'd2, 16'h0100); wr(4'd6, 16'h0003);
    wr(4'd3, 16'h0200); wr(4'd7, 16'h0005);
    access(0, 0, 1, 0, 16'h0100);
    expect_out("R5 slot2 read hit", 1, 4'h4);
    access(0, 0, 1, 1, 16'h0100);
    expect_out("R5 slot2 write filtered", 0, 4'h4);
    access(0, 0, 1, 0, 16'h0200);
    expect_out("R5 slot3 read filtered", 0, 4'h4);
    access(0, 0, 1, 1, 16'h0200);
    expect_out("R5 slot3 write hit", 1, 4'hC);
    wr(4'd9, 16'h000F);
    wr(4'd8, 16'h0003);
    access(0, 0, 1, 0, 16'h0100);
    expect_out("R2 mode 3 acts split", 1, 4'h4);
    wr(4'd9, 16'h000F);
    access(1, 16'h0010, 1, 1, 16'h0200);
    expect_out("R11 two hits one cycle", 1, 4'h9);
    idle();
    expect_out("R11 pulse ends", 0, 4'h9);
    wr(4'd9, 16'h000F);
  endtask

  task automatic t_prog_range();
    wr(4'd8, 16'h0001);
    wr(4'd2, 16'h1200); wr(4'd3, 16'hFF00);
    access(1, 16'h12AB, 0, 0, 0);
    expect_out("R6 in range", 1, 4'h4);
    access(1, 16'h13AB, 0, 0, 0);
    expect_out("R6 outside range", 0, 4'h4);
    access(0, 0, 1, 0, 16'h1200);
    expect_out("R6 data bus ignored", 0, 4'h4);
    wr(4'd9, 16'h000F);
  endtask

  task automatic t_data_range();
    wr(4'd8, 16'h0002);
    wr(4'd2, 16'h0040); wr(4'd3, 16'hFFF0);
    wr(4'd6, 16'h0005);
    wr(4'd7, 16'h0000);
    access(0, 0, 1, 1, 16'h0047);
    expect_out("R7 write in range", 1, 4'h4);
    access(0, 0, 1, 0, 16'h0047);
    expect_out("R7 read filtered", 0, 4'h4);
    access(0, 0, 1, 1, 16'h0050);
    expect_out("R7 outside range", 0, 4'h4);
    access(1, 16'h0040, 0, 0, 0);
    expect_out("R7 fetch ignored", 0, 4'h4);
    wr(4'd6, 16'h0000);
    access(0, 0, 1, 1, 16'h0047);
    expect_out("R4 pair disabled", 0, 4'h4);
    wr(4'd6, 16'h0005);
  endtask

  task automatic t_set_wins();
    fetchValid = 1; fetchAddr = 16'h0010;
    cfgWe = 1; cfgAddr = 4'd9; cfgData = 16'h0005;
    @(negedge clk);
    fetchValid = 0; cfgWe = 0;
    expect_out("R9 hit beats clear", 1, 4'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_prog();
    t_disabled();
    t_split();
    t_prog_range();
    t_data_range();
    t_set_wins();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule